// File: doc/BRIEF.md
# Interrupt Status Aggregator with Global Enable

This block collects the interrupt summary lines of a set of GPIO banks and the request lines of several other peripherals into a single status word. It combines them into one interrupt line for the host processor. Each cycle the status word copies every source line. The bank summaries sit in the low bits and the peripheral sources sit above them in index order. Sources are cleared where they originate, so the status word can only be read.

A mask register holds one enable bit per peripheral source and a global enable bit. The host line is high only while the global enable is set and at least one enabled status bit is set. Bank summaries are masked inside their banks, so here they are always enabled. The host detects the line on its rising edge. Because of this, the line goes low for one cycle whenever any status bit clears. Sources that are still pending then give a fresh rising edge.

Top module: `intc_aggregator`

## Requirements
- R1: Status bits 0 to NUM_BANKS-1 equal the bank summary inputs, sampled one clock earlier.
- R2: Peripheral source k appears at status bit NUM_BANKS+k, sampled one clock earlier. With default parameters this is bits 4 to 9.
- R3: A read at address 0 returns the status word, zero-extended. The value is on reg_rdata_o one cycle after the address is presented. It is zero when no source is pending.
- R4: A write at address 1 loads the mask register, and a read at address 1 returns it. Mask bit k (1 << k) enables peripheral source k. Bit NUM_PERIPH (bit 6 by default) is the global enable. Wider data bits are ignored.
- R5: While the global enable is clear, irq_o stays low whatever is pending.
- R6: With the global enable set, irq_o goes high one cycle after the status word holds a set bank bit or a set, enabled peripheral bit. A set peripheral bit whose enable is clear does not raise irq_o.
- R7: When any status bit clears, irq_o is low in the following cycle. It returns high one cycle later if enabled bits remain pending.
- R8: Writes to address 0 change neither the status word nor the mask register.
- R9: After reset, irq_o is low, the mask register is zero and reg_rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_irq_i | input | NUM_BANKS | GPIO bank interrupt summary lines |
| periph_irq_i | input | NUM_PERIPH | Other peripheral interrupt lines |
| reg_addr_i | input | ADDR_W | Register address: 0 status, 1 mask |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt line to the host |

## Verification
The bench builds the block with its default parameters: four banks, six peripheral sources and a 16-bit data path. This puts the global enable at bit 6 and the top status bit at bit 9. Every peripheral position is walked one at a time, so an off-by-one in the packing or in the mask shift shows up. The defaults also make it possible to drop one source while another stays pending, which exercises the one-cycle low pulse and the rising edge that follows it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_STATUS = 0;
  localparam int REG_MASK   = 1;
endpackage

// File: rtl/intc_src_capture.sv
module intc_src_capture #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  localparam int STAT_W    = NUM_BANKS + NUM_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_BANKS-1:0]  bank_i,
  input  logic [NUM_PERIPH-1:0] periph_i,
  output logic [STAT_W-1:0]     stat_o,
  output logic                  fell_o
);
  logic [STAT_W-1:0] stat_q, stat_d1;
  logic [STAT_W-1:0] fall_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      stat_d1 <= '0;
    end else begin
      stat_q  <= {periph_i, bank_i};
      stat_d1 <= stat_q;
    end
  end

  // per-bit clear detection
  for (genvar i = 0; i < STAT_W; i++) begin : g_fall
    assign fall_vec[i] = stat_d1[i] & ~stat_q[i];
  end

  assign stat_o = stat_q;
  assign fell_o = |fall_vec;
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 1,
  localparam int MASK_W    = NUM_PERIPH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [MASK_W-1:0] mask_o
);
  import intc_pkg::*;

  logic [MASK_W-1:0] mask_q;
  logic              sel_mask;

  assign sel_mask = (addr_i == ADDR_W'(REG_MASK));

  always_ff @(posedge clk) begin
    if (rst)                 mask_q <= '0;
    else if (wr_i && sel_mask) mask_q <= wdata_i[MASK_W-1:0];
  end

  if (DATA_W > MASK_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:MASK_W];
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/intc_irq_drive.sv
module intc_irq_drive #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  localparam int STAT_W    = NUM_BANKS + NUM_PERIPH,
  localparam int MASK_W    = NUM_PERIPH + 1,
  localparam int GEN_BIT   = NUM_PERIPH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              fell_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] enable_vec;
  logic              pending;
  logic              irq_q;

  // bank summaries are masked inside the banks; always enabled here
  assign enable_vec = {mask_i[NUM_PERIPH-1:0], {NUM_BANKS{1'b1}}};
  assign pending    = |(stat_i & enable_vec);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= mask_i[GEN_BIT] & pending & ~fell_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/intc_aggregator.sv
module intc_aggregator #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_BANKS-1:0]  bank_irq_i,
  input  logic [NUM_PERIPH-1:0] periph_irq_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  import intc_pkg::*;

  localparam int STAT_W = NUM_BANKS + NUM_PERIPH;
  localparam int MASK_W = NUM_PERIPH + 1;

  logic [STAT_W-1:0] stat_q;
  logic [MASK_W-1:0] mask_q;
  logic              fell;
  logic [DATA_W-1:0] rdata_q;

  intc_src_capture #(.NUM_BANKS(NUM_BANKS), .NUM_PERIPH(NUM_PERIPH)) i_capture (
    .clk(clk), .rst(rst), .bank_i(bank_irq_i), .periph_i(periph_irq_i),
    .stat_o(stat_q), .fell_o(fell)
  );

  intc_mask_reg #(.NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mask (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .mask_o(mask_q)
  );

  intc_irq_drive #(.NUM_BANKS(NUM_BANKS), .NUM_PERIPH(NUM_PERIPH)) i_drive (
    .clk(clk), .rst(rst), .stat_i(stat_q), .mask_i(mask_q),
    .fell_i(fell), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                                    rdata_q <= '0;
    else if (reg_addr_i == ADDR_W'(REG_STATUS)) rdata_q <= DATA_W'(stat_q);
    else if (reg_addr_i == ADDR_W'(REG_MASK))   rdata_q <= DATA_W'(mask_q);
    else                                        rdata_q <= '0;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/intc_aggregator_chk.sv
module intc_aggregator_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PERIPH = 6,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 1
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_BANKS-1:0]             bank_irq_i,
  input logic [NUM_PERIPH-1:0]            periph_irq_i,
  input logic [ADDR_W-1:0]                reg_addr_i,
  input logic                             reg_wr_i,
  input logic [DATA_W-1:0]                reg_rdata_o,
  input logic                             irq_o,
  input logic [NUM_BANKS+NUM_PERIPH-1:0]  stat_q,
  input logic [NUM_PERIPH:0]              mask_q
);
  localparam int STAT_W = NUM_BANKS + NUM_PERIPH;
  logic [STAT_W-1:0] en_vec;
  assign en_vec = {mask_q[NUM_PERIPH-1:0], {NUM_BANKS{1'b1}}};

  assert_bank_copy_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_q[NUM_BANKS-1:0] == $past(bank_irq_i));

  assert_periph_copy_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_q[STAT_W-1:NUM_BANKS] == $past(periph_irq_i));

  assert_status_read_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == ADDR_W'(0)) |=> reg_rdata_o == DATA_W'($past(stat_q)));

  assert_global_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !mask_q[NUM_PERIPH] |=> !irq_o);

  assert_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (mask_q[NUM_PERIPH] && |(stat_q & en_vec) && stat_q == $past(stat_q)) |=> irq_o);

  assert_drop_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (|($past(stat_q) & ~stat_q)) |=> !irq_o);

  assert_status_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == ADDR_W'(0)) |=> $stable(mask_q));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!irq_o && mask_q == '0 && reg_rdata_o == '0));
endmodule

bind intc_aggregator intc_aggregator_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .bank_irq_i(bank_irq_i), .periph_irq_i(periph_irq_i),
  .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/test_intc_aggregator.sv
`timescale 1ns/1ps
module test_intc_aggregator;
  localparam int NB = 4;
  localparam int NP = 6;
  localparam int DW = 16;
  localparam int AW = 1;
  localparam logic [DW-1:0] GEN = 16'h0040;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] bank = '0;
  logic [NP-1:0] periph = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  intc_aggregator #(.NUM_BANKS(NB), .NUM_PERIPH(NP), .DATA_W(DW), .ADDR_W(AW)) i_intc_aggregator (
    .clk(clk), .rst(rst), .bank_irq_i(bank), .periph_irq_i(periph),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R9 irq", DW'(irq), '0);
    check("R9 rdata", rdata, '0);
    read_reg(1, v); check("R9 mask", v, '0);
    read_reg(0, v); check("R3 status idle", v, '0);
  endtask

  task automatic t_bank();
    logic [DW-1:0] v;
    write_reg(1, GEN);
    read_reg(1, v); check("R4 mask readback", v, GEN);
    bank = 4'b0101; settle(2);
    read_reg(0, v); check("R1 bank bits", v, 16'h0005);
    check("R6 bank raises irq", DW'(irq), 1);
    bank = 4'b1000; settle(3);
    read_reg(0, v); check("R1 bank bit3", v, 16'h0008);
    bank = '0; settle(2);
  endtask

  task automatic t_periph_order();
    logic [DW-1:0] v;
    for (int k = 0; k < NP; k++) begin
      write_reg(1, GEN | (DW'(1) << k));
      periph = NP'(1) << k; settle(2);
      read_reg(0, v); check("R2 periph position", v, DW'(1) << (NB + k));
      check("R6 enabled periph irq", DW'(irq), 1);
      periph = '0; settle(2);
    end
  endtask

  task automatic t_masked();
    write_reg(1, GEN | 16'h0001);
    periph = 6'b000100; settle(3);
    check("R6 masked periph no irq", DW'(irq), 0);
    write_reg(1, GEN | 16'h0004); settle(1);
    check("R4 enable bit 2 raises irq", DW'(irq), 1);
    periph = '0; settle(2);
  endtask

  task automatic t_global_off();
    write_reg(1, 16'hFFBF);
    bank = 4'b0001; periph = '1; settle(3);
    check("R5 global clear holds irq low", DW'(irq), 0);
    bank = '0; periph = '0; settle(2);
  endtask

  task automatic t_fall();
    write_reg(1, GEN | 16'h003F);
    bank = 4'b0001; periph = 6'b000010; settle(3);
    check("R7 pre irq high", DW'(irq), 1);
    bank = 4'b0000;
    settle(1); check("R7 irq before drop", DW'(irq), 1);
    settle(1); check("R7 irq low pulse", DW'(irq), 0);
    settle(1); check("R7 irq re-asserts", DW'(irq), 1);
    periph = '0;
    settle(3); check("R7 all clear irq low", DW'(irq), 0);
  endtask

  task automatic t_status_write();
    logic [DW-1:0] v;
    write_reg(1, GEN | 16'h0005);
    periph = 6'b100000; bank = 4'b0010; settle(2);
    write_reg(0, 16'hFFFF); settle(1);
    read_reg(0, v); check("R8 status unchanged by write", v, 16'h0202);
    read_reg(1, v); check("R8 mask unchanged by status write", v, GEN | 16'h0005);
    write_reg(1, 16'hFF00 | GEN);
    read_reg(1, v); check("R4 upper data ignored", v, GEN);
    bank = '0; periph = '0; settle(2);
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);
    t_reset();
    t_bank();
    t_periph_order();
    t_masked();
    t_global_off();
    t_fall();
    t_status_write();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule